// File: doc/BRIEF.md
# Shared-Datapath Integer ALU

This block is a purely combinational 32-bit integer arithmetic and logic unit for the execute stage of a simple scalar core. It takes two operands, a 4-bit operation code and a 5-bit shift amount. It returns a 32-bit result and a signed-overflow flag in the same cycle.

The unit supports left and right shifts, both logical and arithmetic. It also supports wrapped two's-complement add and subtract, the four bitwise logic functions, and four set-style tests whose outcome lands in bit 0. Add and subtract share one adder: subtraction adds the inverted second operand with a carry-in of 1. All three shifts share one left shifter: a right shift reverses the bit order of the operand before the shifter and again after it, and an arithmetic right shift fills with the sign bit. The result is chosen in small two-way and four-way stages driven by individual opcode bits, with no wide multiplexer or full opcode decoder.

Top module: `alu_core`

## Requirements
- R1: Opcode 000x returns B shifted left by `sa_i` places, with zeros filling the low bits.
- R2: Opcode 001x returns A + B modulo 2^32.
- R3: Opcode 011x returns A − B modulo 2^32.
- R4: `ovf_o` is 1 exactly when the add (001x) or subtract (011x) overflows in signed two's complement, and 0 for every other opcode. When it is 1, `res_o` still holds the wrapped value.
- R5: Opcode 0100 returns B shifted right logically by `sa_i`, with zeros filling the high bits.
- R6: Opcode 0101 returns B shifted right arithmetically by `sa_i`, with copies of B[31] filling the high bits.
- R7: Opcodes 1000, 1010, 1100 and 1110 return A AND B, A OR B, A XOR B and NOT (A OR B) respectively.
- R8: Opcode 1011 returns 1 when A equals B, and 1001 returns 1 when they differ. Otherwise the result is 0, and bits 31:1 are 0 for all four test opcodes (1001, 1011, 1101, 1111).
- R9: Opcode 1111 returns 1 when A, read as signed, is greater than zero. Opcode 1101 returns 1 when A is less than or equal to zero.
- R10: Bit 0 of the opcode has no effect for 000x, 001x and 011x.
- R11: Every shift amount from 0 to 31 is honoured by all three shift kinds, and an amount of 0 returns B unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, and the shifted value |
| op_i | input | 4 | Operation code |
| sa_i | input | 5 | Shift amount, unsigned |
| res_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
No register lies between the inputs and either output, so `res_o` and `ovf_o` are due in the same cycle the operands and opcode are applied. The bench changes inputs on the rising edge of its reference clock and reads both outputs on the following falling edge. By then the combinational paths have settled, and no input changes until the next rising edge. The checker's assertions re-evaluate combinationally whenever an input moves, so they hold at every settled input combination and not only at the sampled ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  typedef struct packed {
    logic       hi_grp;   // logic/compare group
    logic       use_sum;  // adder vs shifter in low group
    logic       sub;      // invert B, carry in 1
    logic       shr;      // right shift via reversal
    logic       sra;      // sign fill
    logic       is_cmp;   // compare vs bitwise in high group
    logic [1:0] lgc_sel;  // and/or/xor/nor
    logic [1:0] cmp_sel;  // ne/eq/le/gt
    logic       ovf_en;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int unsigned OPW = OP_W
) (
  input  logic [OPW-1:0] op_i,
  output alu_ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o         = '0;
    ctrl_o.hi_grp  = op_i[3];
    ctrl_o.use_sum = op_i[1];
    ctrl_o.sub     = op_i[2];
    ctrl_o.shr     = op_i[2];
    ctrl_o.sra     = op_i[2] & op_i[0];
    ctrl_o.is_cmp  = op_i[0];
    ctrl_o.lgc_sel = op_i[2:1];
    ctrl_o.cmp_sel = op_i[2:1];
    ctrl_o.ovf_en  = ~op_i[3] & op_i[1];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W   = 32,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           right_i,
  input  logic           arith_i,
  output logic [W-1:0]   val_o
);
  logic [W-1:0] pre;
  logic [W-1:0] post;
  logic         fill;
  logic [W-1:0] stage [SHW+1];

  assign fill = arith_i & val_i[W-1];

  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      pre[i] = right_i ? val_i[W-1-i] : val_i[i];
    end
  end

  assign stage[0] = pre;

  for (genvar k = 0; k < int'(SHW); k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][W-1-STEP:0], {STEP{fill}}} : stage[k];
  end

  assign post = stage[SHW];

  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      val_o[i] = right_i ? post[W-1-i] : post[i];
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;

  assign b_eff = b_i ^ {W{sub_i}};
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  // same operand signs, different result sign
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) & (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic         hit_o
);
  logic eq, a_zero, gt;

  assign eq     = ~|(a_i ^ b_i);
  assign a_zero = ~|a_i;
  assign gt     = ~a_i[W-1] & ~a_zero;

  always_comb begin
    unique case (sel_i)
      2'b00:   hit_o = ~eq;
      2'b01:   hit_o = eq;
      2'b10:   hit_o = ~gt;
      default: hit_o = gt;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W   = DATA_W,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [SHW-1:0]  sa_i,
  output logic [W-1:0]    res_o,
  output logic            ovf_o
);
  alu_ctrl_t    ctrl;
  logic [W-1:0] shifted, sum, lgc, lo_res, hi_res;
  logic         add_ovf, cmp_hit;

  alu_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  alu_shift #(.W(W)) u_shift (
    .val_i(b_i), .amt_i(sa_i), .right_i(ctrl.shr),
    .arith_i(ctrl.sra), .val_o(shifted)
  );

  alu_addsub #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(ctrl.sub),
    .sum_o(sum), .ovf_o(add_ovf)
  );

  alu_cmp #(.W(W)) u_cmp (
    .a_i(a_i), .b_i(b_i), .sel_i(ctrl.cmp_sel), .hit_o(cmp_hit)
  );

  always_comb begin
    unique case (ctrl.lgc_sel)
      2'b00:   lgc = a_i & b_i;
      2'b01:   lgc = a_i | b_i;
      2'b10:   lgc = a_i ^ b_i;
      default: lgc = ~(a_i | b_i);
    endcase
  end

  assign lo_res = ctrl.use_sum ? sum : shifted;
  assign hi_res = ctrl.is_cmp ? {{(W-1){1'b0}}, cmp_hit} : lgc;
  assign res_o  = ctrl.hi_grp ? hi_res : lo_res;
  assign ovf_o  = ctrl.ovf_en & add_ovf;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = 5
) (
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic [3:0]     op_i,
  input logic [SHW-1:0] sa_i,
  input logic [W-1:0]   res_o,
  input logic           ovf_o
);
  always_comb begin
    p_cmp_upper_zero_r8: assert (!(op_i[3] && op_i[0]) || res_o[W-1:1] == '0)
      else $error("R8 upper bits set");
    p_no_overflow_r4: assert (!(op_i[3] || !op_i[1]) || 1'b1 ? (op_i[3] == 1'b0 && op_i[1]) || !ovf_o : 1'b1)
      else $error("R4 overflow outside add/sub");
    p_ovf_sign_r4: assert (!ovf_o || res_o[W-1] != a_i[W-1])
      else $error("R4 overflow without sign flip");
    p_sll_zero_amt_r11: assert (!(op_i[3:1] == 3'b000 && sa_i == '0) || res_o == b_i)
      else $error("R11 zero shift changed value");
    p_srl_msb_r5: assert (!(op_i == 4'b0100 && sa_i != '0) || !res_o[W-1])
      else $error("R5 msb not zero");
    p_sra_msb_r6: assert (!(op_i == 4'b0101) || res_o[W-1] == b_i[W-1])
      else $error("R6 sign not kept");
    p_and_r7: assert (!(op_i == 4'b1000) || (res_o & ~(a_i & b_i)) == '0)
      else $error("R7 and result");
  end
endmodule

bind alu_core alu_core_chk #(.W(W), .SHW(SHW)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .sa_i(sa_i), .res_o(res_o), .ovf_o(ovf_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  sa;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic        v;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'b0000, 5'd4,  32'h0,         32'h0000_0001, 32'h0000_0010, 1'b0}, // R1
    '{4'b0001, 5'd1,  32'h0,         32'h8000_0001, 32'h0000_0002, 1'b0}, // R10
    '{4'b0010, 5'd0,  32'h7fff_ffff, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R4
    '{4'b0011, 5'd0,  32'h5,         32'h3,         32'h8,         1'b0}, // R2
    '{4'b0110, 5'd0,  32'h3,         32'h5,         32'hffff_fffe, 1'b0}, // R3
    '{4'b0111, 5'd0,  32'h8000_0000, 32'h1,         32'h7fff_ffff, 1'b1}, // R4
    '{4'b0100, 5'd31, 32'h0,         32'h8000_0000, 32'h0000_0001, 1'b0}, // R5
    '{4'b0101, 5'd31, 32'h0,         32'h8000_0000, 32'hffff_ffff, 1'b0}, // R6
    '{4'b0101, 5'd4,  32'h0,         32'h4000_0000, 32'h0400_0000, 1'b0}, // R6
    '{4'b1000, 5'd3,  32'hf0f0_ff00, 32'hff00_f0f0, 32'hf000_f000, 1'b0}, // R7
    '{4'b1010, 5'd0,  32'hf0f0_ff00, 32'hff00_f0f0, 32'hfff0_fff0, 1'b0}, // R7
    '{4'b1100, 5'd0,  32'hf0f0_ff00, 32'hff00_f0f0, 32'h0ff0_0ff0, 1'b0}, // R7
    '{4'b1110, 5'd0,  32'hf0f0_ff00, 32'hff00_f0f0, 32'h000f_000f, 1'b0}, // R7
    '{4'b1011, 5'd0,  32'h1234,      32'h1234,      32'h1,         1'b0}, // R8
    '{4'b1001, 5'd0,  32'h1234,      32'h1234,      32'h0,         1'b0}, // R8
    '{4'b1111, 5'd0,  32'h1,         32'h0,         32'h1,         1'b0}, // R9
    '{4'b1111, 5'd0,  32'h8000_0000, 32'h0,         32'h0,         1'b0}, // R9
    '{4'b1101, 5'd0,  32'h0,         32'h5,         32'h1,         1'b0}, // R9
    '{4'b1101, 5'd0,  32'h7fff_ffff, 32'h0,         32'h0,         1'b0}, // R9
    '{4'b0010, 5'd0,  32'hffff_ffff, 32'h1,         32'h0,         1'b0}, // R4
    '{4'b0110, 5'd0,  32'h0,         32'h8000_0000, 32'h8000_0000, 1'b1}  // R4
  };

  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic [4:0]  sa;
  logic        ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core uut (.a_i(a), .b_i(b), .op_i(op), .sa_i(sa), .res_o(res), .ovf_o(ovf));

  function automatic logic [32:0] model(logic [3:0] o, logic [4:0] s,
                                        logic [31:0] x, logic [31:0] y);
    logic [31:0] r;
    logic        v;
    logic signed [32:0] w;
    v = 1'b0;
    casez (o)
      4'b000?: r = y << s;
      4'b001?: begin w = $signed({x[31], x}) + $signed({y[31], y});
                 r = w[31:0]; v = w[32] != w[31]; end
      4'b0100: r = y >> s;
      4'b0101: r = $unsigned($signed(y) >>> s);
      4'b011?: begin w = $signed({x[31], x}) - $signed({y[31], y});
                 r = w[31:0]; v = w[32] != w[31]; end
      4'b1000: r = x & y;
      4'b1010: r = x | y;
      4'b1100: r = x ^ y;
      4'b1110: r = ~(x | y);
      4'b1011: r = {31'b0, x == y};
      4'b1001: r = {31'b0, x != y};
      4'b1111: r = {31'b0, $signed(x) > 0};
      default: r = {31'b0, $signed(x) <= 0};
    endcase
    return {v, r};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [4:0] s,
                       input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    op = o; sa = s; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] ec, input logic ev);
    n_run++;
    if (res !== ec || ovf !== ev) begin
      n_fail++;
      $display("FAIL %s op=%b sa=%0d: res=%h ovf=%b expected res=%h ovf=%b",
               req, op, sa, res, ovf, ec, ev);
    end
  endtask

  initial begin
    logic [32:0] m;
    op = '0; sa = '0; a = '0; b = '0;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);  // idle inputs give zero, no overflow

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].sa, VECS[i].a, VECS[i].b);
      check("R1-table", VECS[i].c, VECS[i].v);
    end

    // R11: every amount, all shift kinds
    for (int s = 0; s < 32; s++) begin
      apply(4'b0000, 5'(s), 32'hdead_beef, 32'h9abc_def1);
      check("R11", 32'h9abc_def1 << s, 1'b0);
      apply(4'b0100, 5'(s), 32'h0, 32'h9abc_def1);
      check("R11", 32'h9abc_def1 >> s, 1'b0);
      apply(4'b0101, 5'(s), 32'h0, 32'h9abc_def1);
      check("R11", $unsigned($signed(32'h9abc_def1) >>> s), 1'b0);
    end

    // R10: bit 0 is ignored for the don't-care groups
    apply(4'b0111, 5'd0, 32'h10, 32'h3);
    check("R10", 32'hd, 1'b0);
    apply(4'b0001, 5'd8, 32'h0, 32'h0000_00ab);
    check("R10", 32'h0000_ab00, 1'b0);

    // R4: overflow only for add/sub across all opcodes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  o;
      logic [4:0]  s;
      logic [31:0] x, y;
      o = 4'($urandom); s = 5'($urandom);
      x = $urandom; y = (i % 7 == 0) ? x : $urandom;
      if (i % 11 == 0) x = 32'h7fff_ffff ^ {31'b0, x[0]};
      m = model(o, s, x, y);
      apply(o, s, x, y);
      check("R4-R9 random", m[31:0], m[32]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: res=%h expected completion", res);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule